// File: doc/BRIEF.md
# Command Stream Word Parser

This block sits at the front of a channel command processor and walks a stream of 32-bit command words. Each accepted word is either a header, which starts a command, or a payload word that belongs to the most recent header. The parser decodes every header into a flat record: opcode, register offset, class, mask, count field, address, data, lock index and flags. It also works out how many payload words follow that header. Payload words pass through with the opcode and offset of their owning header attached, so a later stage can route them without decoding anything itself.

The payload length depends on the opcode. It can be the number of set bits in a mask field, a literal count, a fixed one or two address words, or a length loaded earlier by a set-payload command and kept in an internal length register. The block only decodes and tags words. Performing register writes, fetching gather memory and granting locks are left to downstream logic. Both sides use valid/ready handshakes, with one output register between them.

Top module: `cmd_word_parser`

## Requirements
- R1: A synchronous reset drops `outValid`, empties the outstanding-payload counter so the next word is a header, and returns the length register to its invalid state.
- R2: A word is decoded as a header only when no payload words remain. A payload word is emitted with `outIsHdr`=0, its raw value on `outData`, and the opcode and offset of its owning header.
- R3: Opcode 0 (set-class) reports the class from bits 15:6, the offset from bits 27:16 and the mask from bits 5:0. Its payload length is the number of set bits in that mask, so a zero mask gives no payload.
- R4: Opcodes 1 and 2 (incrementing and non-incrementing write) report the offset from bits 27:16. Bits 15:0 give both `outCount` and the payload length, so zero gives no payload.
- R5: Opcode 3 (masked write) reports the offset from bits 27:16 and the 16-bit mask from bits 15:0. Its payload length is the number of set bits in the mask.
- R6: Opcode 4 (immediate) puts bits 15:0 on `outData` and the offset from bits 27:16. Opcode 5 (restart) puts the header shifted left by 4 on `outAddr`. Neither takes payload.
- R7: Opcode 6 (gather) reports offset bits 27:16, insert flag bit 15, type flag bit 14 and count bits 13:0, and is followed by exactly one word. Opcode 12 (wide gather) reports count bits 13:0 and is followed by exactly two words.
- R8: Opcode 9 (set-payload) loads bits 15:0 into the length register, marks it valid, shows the value on `outData` and takes no payload. Opcodes 10 and 11 (wide writes) report a 22-bit offset from bits 21:0 and take their payload length from the length register.
- R9: A wide write issued while the length register is invalid sets `outUnknownLen`, reports length 0 and takes no payload. A stored length of zero also gives no payload, with `outUnknownLen` clear.
- R10: Opcode 7 (set-stream-id) puts bits 21:0 on `outData`, and opcode 8 (set-app-id) puts bits 7:0 there. Neither takes payload.
- R11: Opcode 14 (extend) puts bits 7:0 on `outLockIdx`. Sub-opcode bits 27:24 equal to 0 set `outAcquire` and equal to 1 set `outRelease`. Any other sub-opcode, and opcodes 13 and 15, set `outUnknown`. All of these take no payload.
- R12: `outLast` is 1 only on the final payload word of a header and is 0 on every header.
- R13: `inReady` equals `!outValid || outReady`. While `outValid` is high and `outReady` is low, the output record holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted when high with inValid |
| inWord | input | 32 | Command or payload word |
| outValid | output | 1 | Output record valid |
| outReady | input | 1 | Downstream accepts the record |
| outIsHdr | output | 1 | Record is a decoded header |
| outOpcode | output | 4 | Header opcode, or owning header's opcode for payload |
| outOffset | output | 22 | Register offset, or owning header's offset for payload |
| outClass | output | 10 | Class field of set-class |
| outMask | output | 16 | Mask of set-class or masked write |
| outCount | output | 16 | Count field of writes and gathers |
| outPayLen | output | 16 | Payload words following this header |
| outAddr | output | 32 | Restart address |
| outData | output | 32 | Immediate data, id values, set-payload value, or payload word |
| outLockIdx | output | 8 | Lock index of extend |
| outInsert | output | 1 | Gather insert flag |
| outGatherType | output | 1 | Gather type flag |
| outAcquire | output | 1 | Extend acquire lock |
| outRelease | output | 1 | Extend release lock |
| outUnknown | output | 1 | Unknown opcode or extend sub-opcode |
| outUnknownLen | output | 1 | Wide write with invalid length register |
| outLast | output | 1 | Final payload word of its header |

## Verification
The assertions assume that `rst` is high before the first clock edge. They also assume that a word offered on `inWord` with `inValid` counts as accepted only on a cycle where `inReady` is high. The bench meets this by starting with reset asserted and changing inputs only on the falling edge. It holds each word until a rising edge where `inReady` is high, including the cycles in which it stalls the output. The field assertions assume nothing about word contents, so the stimulus covers every opcode, includes payload words whose top bits look like other opcodes, and applies a reset partway through a command.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 4;
  localparam int CNT_W  = 16;
  localparam int OFF_W  = 22;
  localparam int CLS_W  = 10;
  localparam int MSK_W  = 16;
  localparam int IDX_W  = 8;
  localparam int SCMSK_W = 6;

  typedef enum logic [OPC_W-1:0] {
    OP_SETCLS   = 4'd0,
    OP_INCR     = 4'd1,
    OP_NONINCR  = 4'd2,
    OP_MASK     = 4'd3,
    OP_IMM      = 4'd4,
    OP_RESTART  = 4'd5,
    OP_GATHER   = 4'd6,
    OP_STREAM   = 4'd7,
    OP_APP      = 4'd8,
    OP_SETPAY   = 4'd9,
    OP_INCRW    = 4'd10,
    OP_NONINCRW = 4'd11,
    OP_GATHERW  = 4'd12,
    OP_RSVD13   = 4'd13,
    OP_EXTEND   = 4'd14,
    OP_RSVD15   = 4'd15
  } opcode_e;

  localparam logic [3:0] SUB_ACQUIRE = 4'd0;
  localparam logic [3:0] SUB_RELEASE = 4'd1;

  // strobes from control to datapath
  typedef struct packed {
    logic take;
    logic hdr;
    logic lastPay;
  } strobe_t;

  typedef struct packed {
    logic              isHdr;
    logic [OPC_W-1:0]  opcode;
    logic [OFF_W-1:0]  offset;
    logic [CLS_W-1:0]  cls;
    logic [MSK_W-1:0]  mask;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  payLen;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] data;
    logic [IDX_W-1:0]  lockIdx;
    logic              insert;
    logic              gatherType;
    logic              acquire;
    logic              release_;
    logic              unknown;
    logic              unknownLen;
    logic              last;
  } rec_t;
endpackage

// File: rtl/cwp_popcnt.sv
module cwp_popcnt #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  bits,
  output logic [OUT_W-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < IN_W; i++) begin
      ones = ones + OUT_W'(bits[i]);
    end
  end
endmodule

// File: rtl/cwp_ctrl.sv
module cwp_ctrl
  import cwp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             outReady,
  input  logic [OPC_W-1:0] hdrOp,
  input  logic [CNT_W-1:0] hdrLen,
  input  logic [CNT_W-1:0] setPayVal,
  output logic             inReady,
  output logic             outValid,
  output strobe_t          strobe,
  output logic [CNT_W-1:0] payReg,
  output logic             payValid
);
  logic [CNT_W-1:0] remain;
  logic take;
  logic atHdr;

  assign inReady = !outValid || outReady;
  assign take    = inValid && inReady;
  assign atHdr   = (remain == '0);

  assign strobe.take    = take;
  assign strobe.hdr     = atHdr;
  assign strobe.lastPay = !atHdr && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      remain   <= '0;
      payReg   <= '0;
      payValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (take) begin
        outValid <= 1'b1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
      if (take) begin
        if (atHdr) begin
          remain <= hdrLen;
          if (hdrOp == OP_SETPAY) begin
            payReg   <= setPayVal;
            payValid <= 1'b1;
          end
        end else begin
          remain <= remain - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cwp_datapath.sv
module cwp_datapath
  import cwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] inWord,
  input  logic [CNT_W-1:0]  payReg,
  input  logic              payValid,
  output logic [OPC_W-1:0]  hdrOp,
  output logic [CNT_W-1:0]  hdrLen,
  output logic [CNT_W-1:0]  setPayVal,
  output rec_t              outRec
);
  rec_t dec;
  rec_t pay;
  logic [CNT_W-1:0] ones6;
  logic [CNT_W-1:0] ones16;
  logic [OPC_W-1:0] tagOp;
  logic [OFF_W-1:0] tagOff;
  logic [3:0] subOp;

  cwp_popcnt #(.IN_W(SCMSK_W), .OUT_W(CNT_W)) u_pcClass (
    .bits(inWord[SCMSK_W-1:0]), .ones(ones6));
  cwp_popcnt #(.IN_W(MSK_W), .OUT_W(CNT_W)) u_pcMask (
    .bits(inWord[MSK_W-1:0]), .ones(ones16));

  assign subOp     = inWord[27:24];
  assign hdrOp     = inWord[31:28];
  assign hdrLen    = dec.payLen;
  assign setPayVal = inWord[15:0];

  always_comb begin
    dec        = '0;
    dec.isHdr  = 1'b1;
    dec.opcode = inWord[31:28];
    case (opcode_e'(inWord[31:28]))
      OP_SETCLS: begin
        dec.offset = OFF_W'(inWord[27:16]);
        dec.cls    = inWord[15:6];
        dec.mask   = MSK_W'(inWord[SCMSK_W-1:0]);
        dec.payLen = ones6;
      end
      OP_INCR, OP_NONINCR: begin
        dec.offset = OFF_W'(inWord[27:16]);
        dec.count  = inWord[15:0];
        dec.payLen = inWord[15:0];
      end
      OP_MASK: begin
        dec.offset = OFF_W'(inWord[27:16]);
        dec.mask   = inWord[15:0];
        dec.payLen = ones16;
      end
      OP_IMM: begin
        dec.offset = OFF_W'(inWord[27:16]);
        dec.data   = WORD_W'(inWord[15:0]);
      end
      OP_RESTART: begin
        dec.addr = {inWord[27:0], 4'b0000};
      end
      OP_GATHER: begin
        dec.offset     = OFF_W'(inWord[27:16]);
        dec.insert     = inWord[15];
        dec.gatherType = inWord[14];
        dec.count      = CNT_W'(inWord[13:0]);
        dec.payLen     = CNT_W'(1);
      end
      OP_STREAM: begin
        dec.data = WORD_W'(inWord[21:0]);
      end
      OP_APP: begin
        dec.data = WORD_W'(inWord[7:0]);
      end
      OP_SETPAY: begin
        dec.data = WORD_W'(inWord[15:0]);
      end
      OP_INCRW, OP_NONINCRW: begin
        dec.offset = inWord[21:0];
        if (payValid) begin
          dec.count  = payReg;
          dec.payLen = payReg;
        end else begin
          dec.unknownLen = 1'b1;
        end
      end
      OP_GATHERW: begin
        dec.count  = CNT_W'(inWord[13:0]);
        dec.payLen = CNT_W'(2);
      end
      OP_EXTEND: begin
        dec.lockIdx = inWord[7:0];
        if (subOp == SUB_ACQUIRE) begin
          dec.acquire = 1'b1;
        end else if (subOp == SUB_RELEASE) begin
          dec.release_ = 1'b1;
        end else begin
          dec.unknown = 1'b1;
        end
      end
      default: begin
        dec.unknown = 1'b1;
      end
    endcase
  end

  always_comb begin
    pay        = '0;
    pay.opcode = tagOp;
    pay.offset = tagOff;
    pay.data   = inWord;
    pay.last   = strobe.lastPay;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outRec <= '0;
      tagOp  <= '0;
      tagOff <= '0;
    end else if (strobe.take) begin
      if (strobe.hdr) begin
        outRec <= dec;
        tagOp  <= dec.opcode;
        tagOff <= dec.offset;
      end else begin
        outRec <= pay;
      end
    end
  end
endmodule

// File: rtl/cmd_word_parser.sv
module cmd_word_parser
  import cwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord,
  output logic              outValid,
  input  logic              outReady,
  output logic              outIsHdr,
  output logic [OPC_W-1:0]  outOpcode,
  output logic [OFF_W-1:0]  outOffset,
  output logic [CLS_W-1:0]  outClass,
  output logic [MSK_W-1:0]  outMask,
  output logic [CNT_W-1:0]  outCount,
  output logic [CNT_W-1:0]  outPayLen,
  output logic [WORD_W-1:0] outAddr,
  output logic [WORD_W-1:0] outData,
  output logic [IDX_W-1:0]  outLockIdx,
  output logic              outInsert,
  output logic              outGatherType,
  output logic              outAcquire,
  output logic              outRelease,
  output logic              outUnknown,
  output logic              outUnknownLen,
  output logic              outLast
);
  strobe_t          strobe;
  logic [OPC_W-1:0] hdrOp;
  logic [CNT_W-1:0] hdrLen;
  logic [CNT_W-1:0] setPayVal;
  logic [CNT_W-1:0] payReg;
  logic             payValid;
  rec_t             rec;

  cwp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .hdrOp(hdrOp), .hdrLen(hdrLen), .setPayVal(setPayVal),
    .inReady(inReady), .outValid(outValid), .strobe(strobe),
    .payReg(payReg), .payValid(payValid));

  cwp_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .inWord(inWord),
    .payReg(payReg), .payValid(payValid), .hdrOp(hdrOp),
    .hdrLen(hdrLen), .setPayVal(setPayVal), .outRec(rec));

  assign outIsHdr      = rec.isHdr;
  assign outOpcode     = rec.opcode;
  assign outOffset     = rec.offset;
  assign outClass      = rec.cls;
  assign outMask       = rec.mask;
  assign outCount      = rec.count;
  assign outPayLen     = rec.payLen;
  assign outAddr       = rec.addr;
  assign outData       = rec.data;
  assign outLockIdx    = rec.lockIdx;
  assign outInsert     = rec.insert;
  assign outGatherType = rec.gatherType;
  assign outAcquire    = rec.acquire;
  assign outRelease    = rec.release_;
  assign outUnknown    = rec.unknown;
  assign outUnknownLen = rec.unknownLen;
  assign outLast       = rec.last;
endmodule

// File: rtl/cwp_chk.sv
module cwp_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic        outIsHdr,
  input logic [3:0]  outOpcode,
  input logic [15:0] outMask,
  input logic [15:0] outPayLen,
  input logic [31:0] outData,
  input logic        outUnknownLen,
  input logic        outLast
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !outValid);

  // R13
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> inReady);

  // R13
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outIsHdr) && $stable(outOpcode)));

  // R12
  last_on_payload_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outLast) |-> !outIsHdr);

  // R9
  unknown_len_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outUnknownLen) |-> (outIsHdr && outPayLen == 16'd0 && (outOpcode == 4'd10 || outOpcode == 4'd11)));

  // R3
  setclass_len_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outIsHdr && outOpcode == 4'd0) |-> (outPayLen == 16'($countones(outMask))));

  // R7
  gather_len_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outIsHdr && outOpcode == 4'd6) |-> (outPayLen == 16'd1));

  // R2
  empty_hdr_next_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && outIsHdr && outPayLen == 16'd0) |=> (!outValid || outIsHdr));

  logic unusedIn;
  assign unusedIn = inValid;
endmodule

bind cmd_word_parser cwp_chk u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outIsHdr(outIsHdr),
  .outOpcode(outOpcode), .outMask(outMask), .outPayLen(outPayLen),
  .outData(outData), .outUnknownLen(outUnknownLen), .outLast(outLast));

// File: tb/sim_cmd_word_parser.sv
module sim_cmd_word_parser;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst, inValid, outReady;
  logic [31:0] inWord;
  logic inReady, outValid, outIsHdr;
  logic [3:0] outOpcode;
  logic [21:0] outOffset;
  logic [9:0] outClass;
  logic [15:0] outMask, outCount, outPayLen;
  logic [31:0] outAddr, outData;
  logic [7:0] outLockIdx;
  logic outInsert, outGatherType, outAcquire, outRelease, outUnknown, outUnknownLen, outLast;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_word_parser u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .outValid(outValid), .outReady(outReady), .outIsHdr(outIsHdr),
    .outOpcode(outOpcode), .outOffset(outOffset), .outClass(outClass),
    .outMask(outMask), .outCount(outCount), .outPayLen(outPayLen),
    .outAddr(outAddr), .outData(outData), .outLockIdx(outLockIdx),
    .outInsert(outInsert), .outGatherType(outGatherType),
    .outAcquire(outAcquire), .outRelease(outRelease), .outUnknown(outUnknown),
    .outUnknownLen(outUnknownLen), .outLast(outLast));

  typedef struct packed {
    logic [31:0] w;
    logic        h;
    logic [3:0]  op;
    logic [15:0] len;
    logic        lst;
    logic        unk;
    logic        ul;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{32'hA0000010, 1'b1, 4'd10, 16'd0, 1'b0, 1'b0, 1'b1, 4'd9},
    '{32'h01230A95, 1'b1, 4'd0,  16'd3, 1'b0, 1'b0, 1'b0, 4'd3},
    '{32'h11111111, 1'b0, 4'd0,  16'd0, 1'b0, 1'b0, 1'b0, 4'd12},
    '{32'h22222222, 1'b0, 4'd0,  16'd0, 1'b0, 1'b0, 1'b0, 4'd12},
    '{32'h33333333, 1'b0, 4'd0,  16'd0, 1'b1, 1'b0, 1'b0, 4'd12},
    '{32'h10050002, 1'b1, 4'd1,  16'd2, 1'b0, 1'b0, 1'b0, 4'd4},
    '{32'hAAAA0001, 1'b0, 4'd1,  16'd0, 1'b0, 1'b0, 1'b0, 4'd2},
    '{32'hAAAA0002, 1'b0, 4'd1,  16'd0, 1'b1, 1'b0, 1'b0, 4'd12},
    '{32'h20070000, 1'b1, 4'd2,  16'd0, 1'b0, 1'b0, 1'b0, 4'd4},
    '{32'h30088001, 1'b1, 4'd3,  16'd2, 1'b0, 1'b0, 1'b0, 4'd5},
    '{32'hE0000000, 1'b0, 4'd3,  16'd0, 1'b0, 1'b0, 1'b0, 4'd2},
    '{32'hF0000000, 1'b0, 4'd3,  16'd0, 1'b1, 1'b0, 1'b0, 4'd2},
    '{32'h4009BEEF, 1'b1, 4'd4,  16'd0, 1'b0, 1'b0, 1'b0, 4'd6},
    '{32'h50001234, 1'b1, 4'd5,  16'd0, 1'b0, 1'b0, 1'b0, 4'd6},
    '{32'h6010C005, 1'b1, 4'd6,  16'd1, 1'b0, 1'b0, 1'b0, 4'd7},
    '{32'hDEAD0000, 1'b0, 4'd6,  16'd0, 1'b1, 1'b0, 1'b0, 4'd7},
    '{32'h90000003, 1'b1, 4'd9,  16'd0, 1'b0, 1'b0, 1'b0, 4'd8},
    '{32'hB0000040, 1'b1, 4'd11, 16'd3, 1'b0, 1'b0, 1'b0, 4'd8},
    '{32'h00000001, 1'b0, 4'd11, 16'd0, 1'b0, 1'b0, 1'b0, 4'd8},
    '{32'h00000002, 1'b0, 4'd11, 16'd0, 1'b0, 1'b0, 1'b0, 4'd8},
    '{32'h00000003, 1'b0, 4'd11, 16'd0, 1'b1, 1'b0, 1'b0, 4'd8},
    '{32'hC0000010, 1'b1, 4'd12, 16'd2, 1'b0, 1'b0, 1'b0, 4'd7},
    '{32'h12345678, 1'b0, 4'd12, 16'd0, 1'b0, 1'b0, 1'b0, 4'd7},
    '{32'h9ABCDEF0, 1'b0, 4'd12, 16'd0, 1'b1, 1'b0, 1'b0, 4'd7},
    '{32'h90000000, 1'b1, 4'd9,  16'd0, 1'b0, 1'b0, 1'b0, 4'd9},
    '{32'hA0000001, 1'b1, 4'd10, 16'd0, 1'b0, 1'b0, 1'b0, 4'd9},
    '{32'hE0000005, 1'b1, 4'd14, 16'd0, 1'b0, 1'b0, 1'b0, 4'd11},
    '{32'hE1000006, 1'b1, 4'd14, 16'd0, 1'b0, 1'b0, 1'b0, 4'd11},
    '{32'hE7000001, 1'b1, 4'd14, 16'd0, 1'b0, 1'b1, 1'b0, 4'd11},
    '{32'hD0000000, 1'b1, 4'd13, 16'd0, 1'b0, 1'b1, 1'b0, 4'd11},
    '{32'hF0000000, 1'b1, 4'd15, 16'd0, 1'b0, 1'b1, 1'b0, 4'd11},
    '{32'h70123456, 1'b1, 4'd7,  16'd0, 1'b0, 1'b0, 1'b0, 4'd10},
    '{32'h800000AB, 1'b1, 4'd8,  16'd0, 1'b0, 1'b0, 1'b0, 4'd10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one word and return just after the edge that accepts it
  task automatic send(input logic [31:0] w);
    @(negedge clk);
    inValid = 1'b1;
    inWord  = w;
    @(posedge clk);
    while (!inReady) @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; inWord = '0; outReady = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 outValid in reset", 32'(outValid), 32'd0);
    chk("R1 inReady in reset", 32'(inReady), 32'd1);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string t;
      send(VECS[i].w);
      t = $sformatf("R%0d row %0d", VECS[i].rq, i);
      chk({t, " valid"},   32'(outValid),      32'd1);
      chk({t, " isHdr"},   32'(outIsHdr),      32'(VECS[i].h));
      chk({t, " opcode"},  32'(outOpcode),     32'(VECS[i].op));
      chk({t, " payLen"},  32'(outPayLen),     32'(VECS[i].len));
      chk({t, " last"},    32'(outLast),       32'(VECS[i].lst));
      chk({t, " unknown"}, 32'(outUnknown),    32'(VECS[i].unk));
      chk({t, " unkLen"},  32'(outUnknownLen), 32'(VECS[i].ul));
    end

    // R3 zero mask, class and offset fields
    send(32'h01230A80);
    chk("R3 class", 32'(outClass), 32'h2A);
    chk("R3 offset", 32'(outOffset), 32'h123);
    chk("R3 zero mask payLen", 32'(outPayLen), 32'd0);
    // R4 count and offset
    send(32'h10050002);
    chk("R4 count", 32'(outCount), 32'd2);
    chk("R4 offset", 32'(outOffset), 32'h005);
    // R2 payload tag and data
    send(32'h40000000);
    chk("R2 payload isHdr", 32'(outIsHdr), 32'd0);
    chk("R2 payload data", outData, 32'h40000000);
    chk("R2 payload tag offset", 32'(outOffset), 32'h005);
    chk("R2 payload tag opcode", 32'(outOpcode), 32'd1);
    send(32'h40000001);
    chk("R12 final payload last", 32'(outLast), 32'd1);
    // R5 mask field
    send(32'h30088001);
    chk("R5 mask", 32'(outMask), 32'h8001);
    chk("R5 offset", 32'(outOffset), 32'h008);
    send(32'h1); send(32'h2);
    // R6 immediate and restart
    send(32'h4009BEEF);
    chk("R6 imm data", outData, 32'h0000BEEF);
    chk("R6 imm offset", 32'(outOffset), 32'h009);
    send(32'h50001234);
    chk("R6 restart addr", outAddr, 32'h00012340);
    // R7 gather fields
    send(32'h6010C005);
    chk("R7 gather offset", 32'(outOffset), 32'h010);
    chk("R7 gather insert", 32'(outInsert), 32'd1);
    chk("R7 gather type", 32'(outGatherType), 32'd1);
    chk("R7 gather count", 32'(outCount), 32'd5);
    send(32'h0);
    send(32'hC0000123);
    chk("R7 wide gather count", 32'(outCount), 32'h123);
    chk("R7 wide gather payLen", 32'(outPayLen), 32'd2);
    send(32'h0); send(32'h0);
    // R8 wide write offset with stored zero length (R9)
    send(32'hA0123456);
    chk("R8 wide offset", 32'(outOffset), 32'h123456);
    chk("R9 stored zero payLen", 32'(outPayLen), 32'd0);
    send(32'h90000001);
    chk("R8 setpay data", outData, 32'h1);
    send(32'hB0000007);
    chk("R8 wide payLen from reg", 32'(outPayLen), 32'd1);
    send(32'hE0000000);
    chk("R8 wide payload not decoded", 32'(outIsHdr), 32'd0);
    // R11 extend
    send(32'hE0000005);
    chk("R11 acquire", 32'(outAcquire), 32'd1);
    chk("R11 acquire index", 32'(outLockIdx), 32'd5);
    send(32'hE10000F6);
    chk("R11 release", 32'(outRelease), 32'd1);
    chk("R11 release index", 32'(outLockIdx), 32'hF6);
    // R10 ids
    send(32'h70123456);
    chk("R10 stream id", outData, 32'h00123456);
    send(32'h800000AB);
    chk("R10 app id", outData, 32'h000000AB);

    // R13 stall behaviour
    @(negedge clk); outReady = 1'b1;
    @(negedge clk); outReady = 1'b0;
    send(32'h20050001);
    @(negedge clk);
    inValid = 1'b1; inWord = 32'h77777777;
    chk("R13 inReady low when stalled", 32'(inReady), 32'd0);
    @(posedge clk); #1;
    chk("R13 held isHdr", 32'(outIsHdr), 32'd1);
    chk("R13 held opcode", 32'(outOpcode), 32'd2);
    @(negedge clk); outReady = 1'b1;
    @(posedge clk); #1;
    inValid = 1'b0;
    chk("R13 resumed payload", outData, 32'h77777777);
    chk("R13 resumed last", 32'(outLast), 32'd1);

    // R1 reset mid-command clears counter and length register
    send(32'h10050003);
    send(32'h5);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 outValid after reset", 32'(outValid), 32'd0);
    @(negedge clk); rst = 1'b0;
    send(32'hA0000001);
    chk("R1 header after reset", 32'(outIsHdr), 32'd1);
    chk("R1 length reg invalid", 32'(outUnknownLen), 32'd1);

    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule